// File: doc/BRIEF.md
# Gated Event Counter with Pulse and Toggle Gate Modes

This block is a free-running up-counter that advances by one on each cycle where its count-enable input is high. A separate gate input decides whether those counts are accepted. Before the gate reaches the counter it is synchronized and then processed. A polarity option picks which level of the raw gate is active. A toggle option turns each active-going edge into a flip of the processed level. A single-pulse option opens exactly one counting window after software arms it. The toggle and single-pulse options can be used alone or together. When both are on, the counter measures one full period of the gate signal.

Software reaches the block through a small write/read port with three addresses: a configuration word, the count value, and a command word. The command word arms the single-pulse capture and clears the event flag. The processed gate level can always be read back. A falling edge of the processed gate sets a sticky event flag. When its enable is set, that flag raises an interrupt line. The flag and the level readback keep working while gating is switched off, so the gate can be monitored without affecting the count.

Top module: `gated_timer`

## Requirements
- R1: After reset the count reads 0, the configuration word reads 0 and `irq` is low.
- R2: With gate enable (configuration bit 0) clear, the count increments by exactly one for each cycle in which `cntEnIn` is high, whatever the gate input does. It never changes on a cycle where `cntEnIn` is low.
- R3: With gate enable set and both toggle and single-pulse off, counts are accepted only while the processed gate is high. The processed gate is the synchronized gate, XORed with the active-low select in configuration bit 1.
- R4: Bit 6 of the configuration readback always shows the current processed gate level, including while gate enable is clear.
- R5: Each falling edge of the processed gate sets the event flag, read as configuration bit 7. This also happens while gate enable is clear.
- R6: The event flag is cleared only by writing 1 to bit 1 of the command word (address 2). Other writes leave it set. A flag set in the same cycle as a clear wins over the clear.
- R7: `irq` is high exactly when the event flag and the interrupt enable (configuration bit 4) are both set.
- R8: With toggle mode (configuration bit 2) set, the processed gate flips on each active-going edge of the polarity-adjusted gate. The flip state is cleared while toggle mode is off.
- R9: With single-pulse mode (configuration bit 3) set, writing 1 to command bit 0 sets the go bit, read as configuration bit 5. The next rising edge of the pre-pulse gate opens the counting window. The following falling edge closes it and clears the go bit, which signals that the capture is done. No further window opens until go is set again.
- R10: With toggle and single-pulse both set, the counting window spans exactly one full period of the raw gate, from one active-going edge to the next.
- R11: Writing address 1 loads the count. A load wins over a simultaneous increment, and the count wraps from all ones to 0.
- R12: The gate input passes through a synchronizer of `SYNC_STAGES` flops. With 2 stages, a level change driven before a clock edge shows in the status bit after exactly two rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| gateIn | input | 1 | Raw asynchronous gate signal |
| cntEnIn | input | 1 | Count-enable pulse, one increment per high cycle |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address: 0 configuration, 1 count, 2 command |
| wrData | input | CNT_W | Write data |
| rdAddr | input | 2 | Read address: 0 configuration/status, 1 count |
| rdData | output | CNT_W | Read data, combinational from rdAddr |
| irq | output | 1 | Gate-event interrupt request |

## Verification
The bench builds the block with its defaults: a 16-bit count and a 2-stage synchronizer. The narrow count puts the all-ones wrap within reach of a single load followed by a few pulses. The two-stage delay is short enough that the latency check of R12 can sample the exact cycle in which the change appears. A reference model in the bench tracks the toggle state, the go bit and the window, so random sequences of gate edges, polarity and toggle changes, and count pulses can be checked after every step.

// File: rtl/gt_pkg.sv
package gt_pkg;
  localparam int CFG_W = 5;
  localparam logic [1:0] ADDR_CFG = 2'd0;
  localparam logic [1:0] ADDR_COUNT = 2'd1;
  localparam logic [1:0] ADDR_CMD = 2'd2;
  localparam int CMD_GO_BIT = 0;
  localparam int CMD_CLR_BIT = 1;

  // packed MSB first: gateEn lands on bit 0
  typedef struct packed {
    logic irqEn;
    logic pulseEn;
    logic toggleEn;
    logic activeLow;
    logic gateEn;
  } cfg_t;

  typedef struct packed {
    logic step;
    logic load;
  } cnt_cmd_t;
endpackage

// File: rtl/gt_gate_ctrl.sv
module gt_gate_ctrl
  import gt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             gateIn,
  input  logic             cntEnIn,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [CFG_W-1:0] cfgData,
  input  logic [1:0]       cmdData,
  output cfg_t             cfg,
  output logic             goBusy,
  output logic             gateLevel,
  output logic             eventFlag,
  output logic             irq,
  output cnt_cmd_t         cntCmd
);
  logic [SYNC_STAGES-1:0] syncReg;
  logic gSync, polAdj, polPrev, polRise;
  logic tff, toggled, togPrev, togRise, togFall;
  logic pulseActive, gVal, gValPrev, gFall;
  logic cfgWr, cmdWr, setGo, clrReq, hwDone;

  // R12: multi-stage synchronizer on the raw gate
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncReg <= '0;
        else       syncReg <= gateIn;
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncReg <= '0;
        else       syncReg <= {syncReg[SYNC_STAGES-2:0], gateIn};
    end
  endgenerate
  assign gSync = syncReg[SYNC_STAGES-1];

  assign cfgWr  = wrEn && (wrAddr == ADDR_CFG);
  assign cmdWr  = wrEn && (wrAddr == ADDR_CMD);
  assign setGo  = cmdWr && cmdData[CMD_GO_BIT];
  assign clrReq = cmdWr && cmdData[CMD_CLR_BIT];

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)      cfg <= '0;
    else if (cfgWr) cfg <= cfg_t'(cfgData);

  // R3: polarity
  assign polAdj  = gSync ^ cfg.activeLow;
  assign polRise = polAdj && !polPrev;

  // R8: toggle flip-flop, held clear while toggle mode is off
  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      polPrev <= 1'b0;
      tff     <= 1'b0;
    end else begin
      polPrev <= polAdj;
      if (!cfg.toggleEn) tff <= 1'b0;
      else if (polRise)  tff <= ~tff;
    end

  assign toggled = cfg.toggleEn ? tff : polAdj;
  assign togRise = toggled && !togPrev;
  assign togFall = !toggled && togPrev;

  // R9/R10: single-pulse window and go/done handshake
  assign hwDone = cfg.pulseEn && pulseActive && togFall;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      togPrev     <= 1'b0;
      pulseActive <= 1'b0;
      goBusy      <= 1'b0;
    end else begin
      togPrev <= toggled;
      if (!cfg.pulseEn)           pulseActive <= 1'b0;
      else if (hwDone)            pulseActive <= 1'b0;
      else if (goBusy && togRise) pulseActive <= 1'b1;
      if (hwDone)     goBusy <= 1'b0;
      else if (setGo) goBusy <= 1'b1;
    end

  assign gVal      = cfg.pulseEn ? pulseActive : toggled;
  assign gateLevel = gVal;
  assign gFall     = gValPrev && !gVal;

  // R5/R6: sticky event flag, set wins over clear
  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      gValPrev  <= 1'b0;
      eventFlag <= 1'b0;
    end else begin
      gValPrev <= gVal;
      if (gFall)       eventFlag <= 1'b1;
      else if (clrReq) eventFlag <= 1'b0;
    end

  assign irq = eventFlag && cfg.irqEn;

  assign cntCmd.step = cntEnIn && (!cfg.gateEn || gVal);
  assign cntCmd.load = wrEn && (wrAddr == ADDR_COUNT);

  a_r5_fall_sets_flag: assert property (@(posedge clk) disable iff (!rstN)
    $fell(gVal) |=> eventFlag);
  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    eventFlag && !clrReq |=> eventFlag);
  a_r7_irq_masked: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.irqEn |-> !irq);
  a_r9_done_at_close: assert property (@(posedge clk) disable iff (!rstN)
    $fell(goBusy) |-> $fell(pulseActive));
  a_r9_count_in_window: assert property (@(posedge clk) disable iff (!rstN)
    cntCmd.step && cfg.gateEn && cfg.pulseEn |-> pulseActive);
  a_r8_tff_clear: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.toggleEn |=> !tff);
endmodule

// File: rtl/gt_counter.sv
module gt_counter
  import gt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  cnt_cmd_t         cmd,
  input  logic [CNT_W-1:0] loadVal,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  // R11: load has priority, natural wrap
  always_ff @(posedge clk or negedge rstN)
    if (!rstN)         count <= '0;
    else if (cmd.load) count <= loadVal;
    else if (cmd.step) count <= count + ONE;

  a_r2_step_adds_one: assert property (@(posedge clk) disable iff (!rstN)
    cmd.step && !cmd.load |=> count == $past(count) + ONE);
  a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.step && !cmd.load |=> $stable(count));
  a_r11_load_wins: assert property (@(posedge clk) disable iff (!rstN)
    cmd.load |=> count == $past(loadVal));
endmodule

// File: rtl/gated_timer.sv
module gated_timer
  import gt_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             gateIn,
  input  logic             cntEnIn,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  input  logic [1:0]       rdAddr,
  output logic [CNT_W-1:0] rdData,
  output logic             irq
);
  localparam int STAT_W = CFG_W + 3;
  localparam int PAD_W  = CNT_W - STAT_W;

  cfg_t             cfg;
  cnt_cmd_t         cntCmd;
  logic             goBusy, gateLevel, eventFlag;
  logic [CNT_W-1:0] count;
  logic [STAT_W-1:0] statusWord;

  gt_gate_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .gateIn(gateIn), .cntEnIn(cntEnIn),
    .wrEn(wrEn), .wrAddr(wrAddr),
    .cfgData(wrData[CFG_W-1:0]), .cmdData(wrData[1:0]),
    .cfg(cfg), .goBusy(goBusy), .gateLevel(gateLevel),
    .eventFlag(eventFlag), .irq(irq), .cntCmd(cntCmd)
  );

  gt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rstN(rstN), .cmd(cntCmd), .loadVal(wrData), .count(count)
  );

  assign statusWord = {eventFlag, gateLevel, goBusy, cfg};

  always_comb
    case (rdAddr)
      ADDR_CFG:   rdData = {{PAD_W{1'b0}}, statusWord};
      ADDR_COUNT: rdData = count;
      default:    rdData = '0;
    endcase
endmodule

// File: tb/gated_timer_tb.sv
module gated_timer_tb;
  logic clk = 0, rstN = 0, gateIn = 0, cntEnIn = 0, wrEn = 0;
  logic [1:0] wrAddr = 0, rdAddr = 0;
  logic [15:0] wrData = 0, rdData;
  logic irq;
  int nChk = 0, nFail = 0;

  always #5 clk = ~clk;

  gated_timer u_dut (.clk(clk), .rstN(rstN), .gateIn(gateIn), .cntEnIn(cntEnIn),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr),
    .rdData(rdData), .irq(irq));

  // reference model state
  bit mGate, mGe, mAl, mTog, mPul, mIe, mTq, mGo, mAct, mFlag, mPolPrev, mTogPrev, mGvPrev, mGv;
  logic [15:0] mCnt;

  task automatic chk(string tag, int act, int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk); wrEn = 1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] v);
    @(negedge clk); rdAddr = a; #1 v = rdData;
  endtask

  task automatic mSettle();
    bit pol, tog, gv;
    if (!mTog) mTq = 0;
    if (!mPul) mAct = 0;
    pol = mGate ^ mAl;
    if (mTog && pol && !mPolPrev) mTq = ~mTq;
    mPolPrev = pol;
    tog = mTog ? mTq : pol;
    if (mPul) begin
      if (mAct && mTogPrev && !tog) begin mAct = 0; mGo = 0; end
      else if (mGo && !mTogPrev && tog) mAct = 1;
    end
    mTogPrev = tog;
    gv = mPul ? mAct : tog;
    if (mGvPrev && !gv) mFlag = 1;
    mGvPrev = gv; mGv = gv;
  endtask

  task automatic setCfg(bit ge, bit al, bit tg, bit pu, bit ie);
    wr(0, {11'd0, ie, pu, tg, al, ge});
    mGe = ge; mAl = al; mTog = tg; mPul = pu; mIe = ie;
    repeat (8) @(negedge clk);
    mSettle();
  endtask

  task automatic setGate(bit v);
    @(negedge clk); gateIn = v;
    repeat (8) @(negedge clk);
    mGate = v; mSettle();
  endtask

  task automatic pulses(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cntEnIn = 1;
      @(negedge clk); cntEnIn = 0;
    end
    if (!mGe || mGv) mCnt = mCnt + 16'(n);
  endtask

  task automatic clrFlag();
    wr(2, 16'h2); mFlag = 0;
  endtask

  task automatic checkAll(string tag);
    logic [15:0] v;
    rd(0, v);
    chk({tag, " go"}, int'(v[5]), int'(mGo));
    chk({tag, " level"}, int'(v[6]), int'(mGv));
    chk({tag, " flag"}, int'(v[7]), int'(mFlag));
    chk({tag, " irq"}, int'(irq), int'(mFlag & mIe));
    rd(1, v);
    chk({tag, " count"}, int'(v), int'(mCnt));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", nChk - nFail + 1, nChk + 1);
    $finish;
  end

  initial begin
    logic [15:0] v;
    void'($urandom(1234));
    mCnt = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    rd(0, v); chk("R1 cfg", int'(v), 0);
    rd(1, v); chk("R1 count", int'(v), 0);
    chk("R1 irq", int'(irq), 0);
    rstN = 1;
    repeat (2) @(negedge clk);

    // R12: two-edge synchronizer latency
    rdAddr = 0;
    gateIn = 1;
    @(negedge clk); #1 chk("R12 after one edge", int'(rdData[6]), 0);
    @(negedge clk); #1 chk("R12 after two edges", int'(rdData[6]), 1);
    repeat (6) @(negedge clk);
    mGate = 1; mSettle();
    // R4: level readable with gate disabled
    checkAll("R4");
    // R5: falling edge sets flag with gate disabled
    setGate(0);
    checkAll("R5");
    // R7: irq follows enable
    setCfg(0, 0, 0, 0, 1);
    checkAll("R7");
    // R6: unrelated command write leaves flag set
    wr(2, 16'h0);
    checkAll("R6 no clear");
    clrFlag();
    checkAll("R6 cleared");

    // R2: ungated counting
    setCfg(0, 0, 0, 0, 0);
    pulses(5); checkAll("R2 gate low");
    setGate(1); pulses(3); checkAll("R2 gate high");
    setGate(0); clrFlag();
    repeat (4) @(negedge clk); checkAll("R2 idle");

    // R11: load, wrap, load priority
    wr(1, 16'hFFFE); mCnt = 16'hFFFE;
    pulses(3); checkAll("R11 wrap");
    @(negedge clk); wrEn = 1; wrAddr = 1; wrData = 16'h1234; cntEnIn = 1;
    @(negedge clk); wrEn = 0; cntEnIn = 0; mCnt = 16'h1234;
    checkAll("R11 load wins");

    // R3: random gated counting with random polarity
    for (int i = 0; i < 24; i++) begin
      setCfg(1, 1'($urandom), 0, 0, 1'($urandom));
      setGate(1'($urandom));
      pulses(int'($urandom % 6));
      checkAll("R3");
      clrFlag();
    end

    // R8: toggle mode, random gate/polarity/toggle changes
    setGate(0);
    setCfg(1, 0, 1, 0, 0); clrFlag();
    for (int i = 0; i < 30; i++) begin
      case ($urandom % 4)
        0: setGate(~mGate);
        1: setGate(~mGate);
        2: setCfg(1'($urandom), 1'($urandom), 1'($urandom), 0, 1'($urandom));
        default: ;
      endcase
      pulses(int'($urandom % 4));
      checkAll("R8");
    end

    // R9: single-pulse capture
    setCfg(1, 0, 0, 0, 0); setGate(0); clrFlag();
    setCfg(1, 0, 0, 1, 1); clrFlag();
    pulses(2); checkAll("R9 not armed");
    wr(2, 16'h1); mGo = 1;
    pulses(2); checkAll("R9 armed gate low");
    setGate(1); pulses(4); checkAll("R9 window");
    setGate(0); pulses(3); checkAll("R9 done");
    setGate(1); pulses(2); checkAll("R9 no rearm");
    setGate(0); clrFlag();

    // R10: toggle plus single-pulse spans one full period
    setCfg(1, 0, 1, 1, 0); clrFlag();
    wr(2, 16'h1); mGo = 1;
    setGate(1); pulses(2); checkAll("R10 first edge");
    setGate(0); pulses(3); checkAll("R10 mid period");
    setGate(1); pulses(2); checkAll("R10 period end");
    setGate(0); pulses(2); checkAll("R10 after");

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule